// File: doc/BRIEF.md
# Serial GF(2) Quotient Divider for Address-Overlaid Check Fields

This block divides a 56-bit frame, built from a 32-bit data word followed by a 24-bit parity word, by a fixed 25-bit generator polynomial over GF(2). It works one frame bit per clock, most significant bit first. In its main mode it returns the low 24 bits of the quotient and drops the remainder. A receiver whose sender overlays an address on the check field compares this value with its own address.

A second mode runs the same division and returns the 24-bit remainder instead. That remainder is zero for an intact codeword, which suits links where the check field carries no address.

A one-cycle start strobe captures the data, the parity and the mode. A run takes 56 clock cycles and ends with a one-cycle done pulse. The result register changes only in that cycle and holds its value between runs.

Top module: `crc_quotient_divider`

## Requirements
- R1: While reset is asserted and after it is released, done_o is 0 and result_o is 0 until the first run completes.
- R2: With mode_i = 0 at start, result_o is bits 23..0 of the GF(2) quotient of F(x) by G(x) = 0x1FFF409. F is the 56-bit frame {data_i, parity_i}, where data_i bit 31 is the x^55 coefficient and parity_i bit 0 is the x^0 coefficient.
- R3: With mode_i = 1 at start, result_o is the 24-bit remainder F(x) mod G(x).
- R4: done_o is high for exactly one cycle. It rises 56 clock edges after the edge that accepted start_i and is low at every cycle in between.
- R5: result_o changes only in the cycle in which done_o is high, and holds its value when inputs change with no start.
- R6: A start_i pulse that arrives while a run is in progress is ignored, and the run in progress completes with its original result and timing.
- R7: data_i, parity_i and mode_i are captured on the accepting edge. Changing them during a run has no effect on that run's result.
- R8: A frame whose data word is zero gives a quotient of 0 and a remainder equal to parity_i, since its degree is below 24. Equivalently, no quotient bit is produced during the first 24 iterations.
- R9: A frame whose parity word equals (data·x^24) mod G(x) gives a remainder of 0 in mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle strobe that begins a division when idle |
| mode_i | input | 1 | 0 = low quotient bits, 1 = remainder |
| data_i | input | 32 | Data word, the high-order part of the frame |
| parity_i | input | 24 | Parity word, the low-order part of the frame |
| result_o | output | 24 | Quotient low bits or remainder of the last run |
| done_o | output | 1 | One-cycle pulse when result_o is updated |

## Verification
The bench checks the exact cycle of the done pulse. A design whose step counter is off by one would pulse a cycle early or late, or hold done high for two cycles. It checks frames whose quotient is known by hand, and frames whose high quotient bits are set while the low 24 bits are zero. A design that kept the wrong end of the quotient, or returned the remainder in quotient mode, fails those frames. It also injects a second start strobe and changes the inputs in the middle of a run. A design that restarts, or that reads the live inputs instead of captured copies, then returns a value for the wrong frame. Zero-data frames and valid codewords catch a working register that is not cleared at load, because such a register leaves nonzero quotient or remainder bits.

// File: rtl/gf2_div_pkg.sv
package gf2_div_pkg;
    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_CHK_W  = 24;
    localparam logic [DEF_CHK_W:0] DEF_GEN_POLY = 25'h1FFF409;

    typedef enum logic {
        MODE_QUOTIENT  = 1'b0,
        MODE_REMAINDER = 1'b1
    } div_mode_e;
endpackage

// File: rtl/gf2_div_step.sv
module gf2_div_step #(
    parameter int unsigned CHK_W = 24,
    parameter logic [CHK_W:0] POLY = 25'h1FFF409
) (
    input  logic [CHK_W-1:0] rem_i,
    input  logic             bit_i,
    output logic [CHK_W-1:0] rem_o,
    output logic             qbit_o
);
    logic [CHK_W:0] widened;

    always_comb begin
        widened = {rem_i, bit_i};
        qbit_o  = widened[CHK_W];
        rem_o   = widened[CHK_W-1:0] ^ (qbit_o ? POLY[CHK_W-1:0] : '0);
    end
endmodule

// File: rtl/gf2_div_seq.sv
module gf2_div_seq #(
    parameter int unsigned FRAME_W = 56,
    localparam int unsigned CNT_W  = $clog2(FRAME_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             load_o,
    output logic             step_o,
    output logic             last_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (!seq_q.busy) begin
            if (start_i) begin
                seq_d.busy = 1'b1;
                seq_d.cnt  = '0;
            end
        end else if (seq_q.cnt == LAST_STEP) begin
            seq_d.busy = 1'b0;
            seq_d.done = 1'b1;
        end else begin
            seq_d.cnt = seq_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign load_o = !seq_q.busy && start_i;
    assign step_o = seq_q.busy;
    assign last_o = seq_q.busy && (seq_q.cnt == LAST_STEP);
    assign cnt_o  = seq_q.cnt;
    assign done_o = seq_q.done;

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(last_o));
    assert_busy_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && !last_o && start_i) |=> (step_o && cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/crc_quotient_divider.sv
module crc_quotient_divider
    import gf2_div_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned CHK_W  = DEF_CHK_W,
    parameter logic [CHK_W:0] GEN_POLY = DEF_GEN_POLY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  parity_i,
    output logic [CHK_W-1:0]  result_o,
    output logic              done_o
);
    localparam int unsigned FRAME_W = DATA_W + CHK_W;
    localparam int unsigned CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LEAD_STEPS = CNT_W'(CHK_W);

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [CHK_W-1:0]   rem;
        logic [CHK_W-1:0]   quot;
        div_mode_e          mode;
        logic [CHK_W-1:0]   result;
    } dp_t;

    dp_t dp_d, dp_q;

    logic             load, step, last;
    logic [CNT_W-1:0] cnt;
    logic [CHK_W-1:0] rem_nxt;
    logic             qbit;
    logic [CHK_W-1:0] quot_nxt;

    gf2_div_seq #(.FRAME_W(FRAME_W)) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .last_o  (last),
        .cnt_o   (cnt),
        .done_o  (done_o)
    );

    gf2_div_step #(.CHK_W(CHK_W), .POLY(GEN_POLY)) step_i (
        .rem_i  (dp_q.rem),
        .bit_i  (dp_q.frame[FRAME_W-1]),
        .rem_o  (rem_nxt),
        .qbit_o (qbit)
    );

    assign quot_nxt = {dp_q.quot[CHK_W-2:0], qbit};

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.frame = {data_i, parity_i};
            dp_d.rem   = '0;
            dp_d.quot  = '0;
            dp_d.mode  = div_mode_e'(mode_i);
        end else if (step) begin
            dp_d.frame = {dp_q.frame[FRAME_W-2:0], 1'b0};
            dp_d.rem   = rem_nxt;
            dp_d.quot  = quot_nxt;
            if (last) begin
                dp_d.result = (dp_q.mode == MODE_REMAINDER) ? rem_nxt : quot_nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign result_o = dp_q.result;

    assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));
    assert_lead_quot_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt < LEAD_STEPS) |-> !qbit);
    assert_mode_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> $stable(dp_q.mode));
endmodule

// File: tb/crc_quotient_divider_tb_top.sv
module crc_quotient_divider_tb_top;
    localparam logic [24:0] POLY = 25'h1FFF409;
    localparam int WATCHDOG_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [31:0] data = '0;
    logic [23:0] parity = '0;
    logic [23:0] result;
    logic        done;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    crc_quotient_divider dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
        .data_i(data), .parity_i(parity), .result_o(result), .done_o(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic void ref_div(input logic [31:0] d, input logic [23:0] p,
                                    output logic [31:0] q, output logic [23:0] r);
        logic [55:0] v;
        v = {d, p};
        q = '0;
        for (int i = 55; i >= 24; i--) begin
            if (v[i]) begin
                v ^= {31'b0, POLY} << (i - 24);
                q[i-24] = 1'b1;
            end
        end
        r = v[23:0];
    endfunction

    // disturb: 0 none, 1 change inputs mid-run, 2 change inputs and pulse start
    task automatic run(input logic [31:0] d, input logic [23:0] p, input logic m,
                       input int disturb, output logic [23:0] res);
        bit early;
        @(negedge clk);
        data = d; parity = p; mode = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        early = 1'b0;
        for (int i = 1; i <= 56; i++) begin
            if (disturb != 0 && i == 20) begin
                data = ~d; parity = ~p; mode = ~m; start = (disturb == 2);
            end
            if (i == 21) start = 1'b0;
            @(negedge clk);
            if (i < 56 && done) early = 1'b1;
        end
        chk("R4 done early", {31'b0, early}, 32'd0);
        chk("R4 done at edge 56", {31'b0, done}, 32'd1);
        res = result;
        @(negedge clk);
        chk("R4 done one cycle", {31'b0, done}, 32'd0);
    endtask

    task automatic run_check(input string req, input logic [31:0] d, input logic [23:0] p,
                             input logic m, input int disturb);
        logic [31:0] q;
        logic [23:0] r, res;
        ref_div(d, p, q, r);
        run(d, p, m, disturb, res);
        chk(req, {8'b0, res}, {8'b0, (m ? r : q[23:0])});
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 done in reset", {31'b0, done}, 32'd0);
        chk("R1 result in reset", {8'b0, result}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 done after reset", {31'b0, done}, 32'd0);
        chk("R1 result after reset", {8'b0, result}, 32'd0);
    endtask

    task automatic t_known();
        logic [23:0] res;
        run(32'h0000_0001, 24'hFFF409, 1'b0, 0, res);
        chk("R2 frame equal to G quotient", {8'b0, res}, 32'd1);
        run(32'h0000_0001, 24'hFFF409, 1'b1, 0, res);
        chk("R3 frame equal to G remainder", {8'b0, res}, 32'd0);
        run(32'h0000_0003, 24'hFFE812, 1'b0, 0, res);
        chk("R2 frame equal to G*x quotient", {8'b0, res}, 32'd2);
        // G*x^31: quotient x^31, low 24 bits zero
        run(32'hFFFA_0480, 24'h000000, 1'b0, 0, res);
        chk("R2 high quotient bit only", {8'b0, res}, 32'd0);
    endtask

    task automatic t_patterns();
        logic [31:0] d;
        logic [23:0] p;
        d = 32'h1234_5678; p = 24'h9ABCDE;
        for (int k = 0; k < 6; k++) begin
            run_check("R2 quotient pattern", d, p, 1'b0, 0);
            run_check("R3 remainder pattern", d, p, 1'b1, 0);
            d = {d[30:0], d[31] ^ d[21] ^ d[1] ^ d[0]} ^ 32'hA5A5_0F0F;
            p = {p[22:0], p[23] ^ p[16]} ^ 24'h3C3C3C;
        end
        run_check("R2 all ones", 32'hFFFF_FFFF, 24'hFFFFFF, 1'b0, 0);
        run_check("R3 all ones", 32'hFFFF_FFFF, 24'hFFFFFF, 1'b1, 0);
    endtask

    task automatic t_data_zero();
        logic [23:0] res;
        run(32'h0, 24'hC0FFEE, 1'b0, 0, res);
        chk("R8 zero data quotient", {8'b0, res}, 32'd0);
        run(32'h0, 24'hC0FFEE, 1'b1, 0, res);
        chk("R8 zero data remainder", {8'b0, res}, 32'h00C0FFEE);
        run(32'h0, 24'h000000, 1'b1, 0, res);
        chk("R8 zero frame remainder", {8'b0, res}, 32'd0);
    endtask

    task automatic t_codeword();
        logic [31:0] q;
        logic [23:0] r, res;
        ref_div(32'hDEAD_BEEF, 24'h0, q, r);
        run(32'hDEAD_BEEF, r, 1'b1, 0, res);
        chk("R9 codeword remainder", {8'b0, res}, 32'd0);
        ref_div(32'h0000_8001, 24'h0, q, r);
        run(32'h0000_8001, r, 1'b1, 0, res);
        chk("R9 codeword remainder 2", {8'b0, res}, 32'd0);
    endtask

    task automatic t_busy_start();
        run_check("R6 start while busy, quotient", 32'h0BAD_F00D, 24'h55AA33, 1'b0, 2);
        run_check("R6 start while busy, remainder", 32'h0BAD_F00D, 24'h55AA33, 1'b1, 2);
    endtask

    task automatic t_mode_latch();
        run_check("R7 inputs change mid-run, quotient", 32'hCAFE_1234, 24'h0F1E2D, 1'b0, 1);
        run_check("R7 inputs change mid-run, remainder", 32'hCAFE_1234, 24'h0F1E2D, 1'b1, 1);
    endtask

    task automatic t_hold();
        logic [23:0] res;
        bit moved;
        run(32'h7777_1111, 24'h2468AC, 1'b0, 0, res);
        @(negedge clk);
        data = 32'h0; parity = 24'hFFFFFF; mode = 1'b1;
        moved = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (result !== res || done !== 1'b0) moved = 1'b1;
        end
        chk("R5 result holds without start", {31'b0, moved}, 32'd0);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_known();
        t_patterns();
        t_data_zero();
        t_codeword();
        t_busy_start();
        t_mode_latch();
        t_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule